// File: doc/BRIEF.md
# Flash Command Sequencer

This block sits behind the write port of a parallel NOR-style flash and turns the host's multi-cycle write sequences into single operation requests. The two active-low strobes, write enable and chip enable, are brought into the system clock domain. A bus write cycle lasts while both strobes are low. The address is taken when that overlap begins, which is the later of the two falling edges. The data is taken when the overlap ends, which is the earlier of the two rising edges. Each completed bus write is then fed to a protection-aware command decoder. The decoder recognises a word program, a sector erase, a block erase, a chip erase, product-identification entry, parameter-query (CFI) entry and the exit back to array reads.

A recognised program or erase produces a one-cycle request carrying the operation type, the target address and the data word, and the block marks itself busy. Busy holds until the downstream program/erase engine returns a done pulse, and every bus write in between is dropped. A registered read-mode selection tells the read path whether to return array data, identification words or query data. The block itself supplies the two identification words.

Top module: `flash_cmd_seq`

## Requirements
- R1: After reset the read mode is array (code 0), busy is low, no request is raised and the identification output is 0000H.
- R2: A bus write cycle takes its address from the moment both strobes are low (the later falling edge) and its data from the moment the first strobe returns high (the earlier rising edge). Changes after those points have no effect, for write-enable-led and chip-enable-led cycles alike.
- R3: The writes AAH@5555H, 55H@2AAAH, A0H@5555H followed by any fourth write raise a request of type 0 (program) with that fourth write's full address and data word.
- R4: AAH@5555H, 55H@2AAAH, 80H@5555H, AAH@5555H, 55H@2AAAH, then 30H at any address, raise type 1 (sector erase) with address bits below bit 10 cleared.
- R5: The same five-write prefix, then 50H at any address, raises type 2 (block erase) with address bits below bit 15 cleared.
- R6: The same prefix, then 10H written to 5555H, raises type 3 (chip erase) with address 0. A final 10H at any other address raises nothing.
- R7: AAH@5555H, 55H@2AAAH, 90H@5555H selects identification mode (code 1). In it, the identification output is 00BFH at address 0, 2761H at address 1 and 0000H elsewhere. In other modes it is 0000H.
- R8: AAH@5555H, 55H@2AAAH, 98H@5555H selects query mode (code 2). Stray or aborted writes leave the mode unchanged.
- R9: A single F0H write at any address, given with no sequence in progress, returns the read mode to array. So does AAH@5555H, 55H@2AAAH, F0H@5555H.
- R10: A write that does not match the expected step returns the decoder to its first step, raises nothing and leaves the read mode unchanged. Only data bits 7..0 and address bits 15..0 are compared.
- R11: Raising a request sets busy. A done pulse clears it. While busy, every write is ignored, exit included.
- R12: A done pulse in the same cycle as a decoded write clears busy first, so that write is accepted.
- R13: The request is a single-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| we_n | input | 1 | Write enable strobe, active low, asynchronous to clk |
| ce_n | input | 1 | Chip enable strobe, active low, asynchronous to clk |
| addr | input | 20 | Word address from the host bus |
| din | input | 16 | Data word from the host bus |
| op_done | input | 1 | Pulse from the program/erase engine at completion |
| op_valid | output | 1 | One-cycle operation request |
| op_type | output | 2 | 0 program, 1 sector erase, 2 block erase, 3 chip erase |
| op_addr | output | 20 | Target address, aligned for erases |
| op_data | output | 16 | Data word for program |
| read_mode | output | 2 | 0 array, 1 identification, 2 query |
| busy | output | 1 | Operation outstanding, writes ignored |
| id_word | output | 16 | Identification word for the current address |

## Verification
The engine's completion pulse and a newly decoded bus write can land in the same clock cycle. The bench provokes this by counting the strobe synchronizer and decode registers, so that the done pulse coincides with the internal write event for the first unlock write that follows a program. It judges the result at the ports: a program issued from the remaining three writes shows the write was taken. A control run without the aligned done must raise no request.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

  typedef enum logic [1:0] {
    RM_ARRAY = 2'd0,
    RM_ID    = 2'd1,
    RM_CFI   = 2'd2
  } rmode_e;

  typedef enum logic [1:0] {
    OP_PROG   = 2'd0,
    OP_SECTOR = 2'd1,
    OP_BLOCK  = 2'd2,
    OP_CHIP   = 2'd3
  } op_e;

  typedef enum logic [2:0] {
    S_IDLE,
    S_KEY1,
    S_KEY2,
    S_PROG,
    S_ERA3,
    S_ERA4,
    S_ERA5
  } seq_e;

  localparam int          CMP_AW    = 16;
  localparam logic [15:0] ADR_KEY_A = 16'h5555;
  localparam logic [15:0] ADR_KEY_B = 16'h2AAA;
  localparam logic [7:0]  B_KEY_A   = 8'hAA;
  localparam logic [7:0]  B_KEY_B   = 8'h55;
  localparam logic [7:0]  B_PROG    = 8'hA0;
  localparam logic [7:0]  B_ERASE   = 8'h80;
  localparam logic [7:0]  B_IDENT   = 8'h90;
  localparam logic [7:0]  B_QUERY   = 8'h98;
  localparam logic [7:0]  B_EXIT    = 8'hF0;
  localparam logic [7:0]  B_SECTOR  = 8'h30;
  localparam logic [7:0]  B_BLOCK   = 8'h50;
  localparam logic [7:0]  B_CHIP    = 8'h10;

endpackage

// File: rtl/fcs_strobe_sync.sv
module fcs_strobe_sync #(
  parameter int AW          = 20,
  parameter int DW          = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we_n,
  input  logic          ce_n,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] din,
  output logic          wr_stb,
  output logic [AW-1:0] wr_addr,
  output logic [DW-1:0] wr_data
);

  localparam int TOP = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] we_sh;
  logic [SYNC_STAGES-1:0] ce_sh;
  logic                   act;
  logic                   act_q;
  logic                   cyc_start;
  logic                   cyc_end;
  logic [AW-1:0]          addr_cap;
  logic [DW-1:0]          data_cap;

  // strobe synchronizers, idle high
  always_ff @(posedge clk) begin
    if (rst) begin
      we_sh <= '1;
      ce_sh <= '1;
    end else begin
      we_sh <= {we_sh[TOP-1:0], we_n};
      ce_sh <= {ce_sh[TOP-1:0], ce_n};
    end
  end

  // a bus write lasts while both strobes are low
  assign act       = ~we_sh[TOP] & ~ce_sh[TOP];
  assign cyc_start = act & ~act_q;
  assign cyc_end   = ~act & act_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      act_q    <= 1'b0;
      addr_cap <= '0;
      data_cap <= '0;
      wr_stb   <= 1'b0;
      wr_addr  <= '0;
      wr_data  <= '0;
    end else begin
      act_q  <= act;
      wr_stb <= cyc_end;
      if (cyc_start) addr_cap <= addr;
      if (act)       data_cap <= din;
      if (cyc_end) begin
        wr_addr <= addr_cap;
        wr_data <= data_cap;
      end
    end
  end

  a_r2_stb_gap: assert property (@(posedge clk) disable iff (rst)
    wr_stb |=> !wr_stb);

endmodule

// File: rtl/fcs_seq_fsm.sv
module fcs_seq_fsm
  import flash_cmd_pkg::*;
#(
  parameter int AW       = 20,
  parameter int DW       = 16,
  parameter int SECT_LSB = 10,
  parameter int BLK_LSB  = 15
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_stb,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic          op_done,
  output logic          op_valid,
  output op_e           op_type,
  output logic [AW-1:0] op_addr,
  output logic [DW-1:0] op_data,
  output rmode_e        read_mode,
  output logic          busy
);

  seq_e          st, st_n;
  rmode_e        mode_n;
  logic          accept;
  logic          issue;
  op_e           itype;
  logic [AW-1:0] iaddr;
  logic [7:0]    lo;
  logic [15:0]   al;
  logic          busy_n;

  assign lo     = wr_data[7:0];
  assign al     = wr_addr[CMP_AW-1:0];
  // completion frees the block before the write is judged
  assign accept = wr_stb && (!busy || op_done);

  always_comb begin
    st_n   = st;
    mode_n = read_mode;
    issue  = 1'b0;
    itype  = OP_PROG;
    iaddr  = wr_addr;
    if (accept) begin
      st_n = S_IDLE;
      unique case (st)
        S_IDLE: begin
          if (lo == B_KEY_A && al == ADR_KEY_A) st_n = S_KEY1;
          else if (lo == B_EXIT)                mode_n = RM_ARRAY;
        end
        S_KEY1: begin
          if (lo == B_KEY_B && al == ADR_KEY_B) st_n = S_KEY2;
        end
        S_KEY2: begin
          if (al == ADR_KEY_A) begin
            case (lo)
              B_PROG:  st_n   = S_PROG;
              B_ERASE: st_n   = S_ERA3;
              B_IDENT: mode_n = RM_ID;
              B_QUERY: mode_n = RM_CFI;
              B_EXIT:  mode_n = RM_ARRAY;
              default: st_n   = S_IDLE;
            endcase
          end
        end
        S_PROG: begin
          issue = 1'b1;
          itype = OP_PROG;
        end
        S_ERA3: begin
          if (lo == B_KEY_A && al == ADR_KEY_A) st_n = S_ERA4;
        end
        S_ERA4: begin
          if (lo == B_KEY_B && al == ADR_KEY_B) st_n = S_ERA5;
        end
        S_ERA5: begin
          if (lo == B_SECTOR) begin
            issue = 1'b1;
            itype = OP_SECTOR;
            iaddr = {wr_addr[AW-1:SECT_LSB], {SECT_LSB{1'b0}}};
          end else if (lo == B_BLOCK) begin
            issue = 1'b1;
            itype = OP_BLOCK;
            iaddr = {wr_addr[AW-1:BLK_LSB], {BLK_LSB{1'b0}}};
          end else if (lo == B_CHIP && al == ADR_KEY_A) begin
            issue = 1'b1;
            itype = OP_CHIP;
            iaddr = '0;
          end
        end
        default: st_n = S_IDLE;
      endcase
    end
  end

  always_comb begin
    if (issue)        busy_n = 1'b1;
    else if (op_done) busy_n = 1'b0;
    else              busy_n = busy;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= S_IDLE;
      read_mode <= RM_ARRAY;
      busy      <= 1'b0;
      op_valid  <= 1'b0;
      op_type   <= OP_PROG;
      op_addr   <= '0;
      op_data   <= '0;
    end else begin
      st        <= st_n;
      read_mode <= mode_n;
      busy      <= busy_n;
      op_valid  <= issue;
      if (issue) begin
        op_type <= itype;
        op_addr <= iaddr;
        op_data <= wr_data;
      end
    end
  end

  a_r11_ignore_busy: assert property (@(posedge clk) disable iff (rst)
    (wr_stb && busy && !op_done) |=> (!op_valid && $stable(read_mode)));

  a_r11_busy_on_issue: assert property (@(posedge clk) disable iff (rst)
    op_valid |-> busy);

  a_r11_busy_release: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> $past(op_done));

  a_r13_op_pulse: assert property (@(posedge clk) disable iff (rst)
    op_valid |=> !op_valid);

  a_r4_sector_align: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_type == OP_SECTOR) |-> (op_addr[SECT_LSB-1:0] == '0));

  a_r5_block_align: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_type == OP_BLOCK) |-> (op_addr[BLK_LSB-1:0] == '0));

  a_r6_chip_zero: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_type == OP_CHIP) |-> (op_addr == '0));

  a_r10_mode_legal: assert property (@(posedge clk) disable iff (rst)
    read_mode != 2'd3);

endmodule

// File: rtl/fcs_id_rom.sv
module fcs_id_rom
  import flash_cmd_pkg::*;
#(
  parameter int          AW     = 20,
  parameter int          DW     = 16,
  parameter logic [15:0] MFR_ID = 16'h00BF,
  parameter logic [15:0] DEV_ID = 16'h2761
) (
  input  logic          clk,
  input  logic          rst,
  input  rmode_e        read_mode,
  input  logic [AW-1:0] addr,
  output logic [DW-1:0] id_word
);

  localparam logic [AW-1:0] ADR_MFR = AW'(0);
  localparam logic [AW-1:0] ADR_DEV = AW'(1);

  logic [DW-1:0] word_n;

  always_comb begin
    word_n = '0;
    if (read_mode == RM_ID) begin
      if (addr == ADR_MFR)      word_n = DW'(MFR_ID);
      else if (addr == ADR_DEV) word_n = DW'(DEV_ID);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) id_word <= '0;
    else     id_word <= word_n;
  end

  a_r7_id_quiet: assert property (@(posedge clk) disable iff (rst)
    (read_mode != RM_ID) |=> (id_word == '0));

endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq
  import flash_cmd_pkg::*;
#(
  parameter int AW          = 20,
  parameter int DW          = 16,
  parameter int SYNC_STAGES = 2,
  parameter int SECT_LSB    = 10,
  parameter int BLK_LSB     = 15
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we_n,
  input  logic          ce_n,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] din,
  input  logic          op_done,
  output logic          op_valid,
  output logic [1:0]    op_type,
  output logic [AW-1:0] op_addr,
  output logic [DW-1:0] op_data,
  output logic [1:0]    read_mode,
  output logic          busy,
  output logic [DW-1:0] id_word
);

  logic          wr_stb;
  logic [AW-1:0] wr_addr;
  logic [DW-1:0] wr_data;
  op_e           op_type_i;
  rmode_e        mode_i;

  fcs_strobe_sync #(
    .AW(AW), .DW(DW), .SYNC_STAGES(SYNC_STAGES)
  ) u_sync (
    .clk(clk), .rst(rst), .we_n(we_n), .ce_n(ce_n),
    .addr(addr), .din(din),
    .wr_stb(wr_stb), .wr_addr(wr_addr), .wr_data(wr_data)
  );

  fcs_seq_fsm #(
    .AW(AW), .DW(DW), .SECT_LSB(SECT_LSB), .BLK_LSB(BLK_LSB)
  ) u_fsm (
    .clk(clk), .rst(rst),
    .wr_stb(wr_stb), .wr_addr(wr_addr), .wr_data(wr_data),
    .op_done(op_done),
    .op_valid(op_valid), .op_type(op_type_i), .op_addr(op_addr),
    .op_data(op_data), .read_mode(mode_i), .busy(busy)
  );

  fcs_id_rom #(
    .AW(AW), .DW(DW)
  ) u_id (
    .clk(clk), .rst(rst), .read_mode(mode_i), .addr(addr), .id_word(id_word)
  );

  assign op_type   = op_type_i;
  assign read_mode = mode_i;

endmodule

// File: tb/test_flash_cmd_seq.sv
module test_flash_cmd_seq;

  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        we_n = 1'b1;
  logic        ce_n = 1'b1;
  logic [19:0] addr = '0;
  logic [15:0] din = '0;
  logic        op_done = 1'b0;
  logic        op_valid;
  logic [1:0]  op_type;
  logic [19:0] op_addr;
  logic [15:0] op_data;
  logic [1:0]  read_mode;
  logic        busy;
  logic [15:0] id_word;

  int errs = 0;
  int checks = 0;
  int op_cnt = 0;
  int dbl = 0;
  bit prev_v = 1'b0;
  bit ended = 1'b0;
  logic [1:0]  m_type;
  logic [19:0] m_addr;
  logic [15:0] m_data;

  always #(CLK_P/2) clk = ~clk;

  flash_cmd_seq i_flash_cmd_seq (
    .clk(clk), .rst(rst), .we_n(we_n), .ce_n(ce_n), .addr(addr), .din(din),
    .op_done(op_done), .op_valid(op_valid), .op_type(op_type),
    .op_addr(op_addr), .op_data(op_data), .read_mode(read_mode),
    .busy(busy), .id_word(id_word)
  );

  always @(negedge clk) begin
    if (!rst) begin
      if (op_valid) begin
        op_cnt++;
        m_type = op_type;
        m_addr = op_addr;
        m_data = op_data;
        if (prev_v) dbl++;
      end
      prev_v = op_valid;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!ended) begin
      ended = 1'b1;
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  endtask

  task automatic wr(input logic [19:0] a, input logic [15:0] d);
    @(negedge clk);
    addr = a; din = d; we_n = 1'b0; ce_n = 1'b0;
    repeat (4) @(negedge clk);
    we_n = 1'b1; ce_n = 1'b1;
    repeat (5) @(negedge clk);
  endtask

  // write whose internal event coincides with a done pulse
  task automatic wr_done(input logic [19:0] a, input logic [15:0] d);
    @(negedge clk);
    addr = a; din = d; we_n = 1'b0; ce_n = 1'b0;
    repeat (4) @(negedge clk);
    we_n = 1'b1; ce_n = 1'b1;
    repeat (3) @(negedge clk);
    op_done = 1'b1;
    @(negedge clk);
    op_done = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic wr_split(input logic [19:0] a, input logic [15:0] d,
                          input logic [15:0] d2, input logic [15:0] d3,
                          input bit we_first);
    @(negedge clk);
    addr = a ^ 20'h0F0F0; din = d;
    if (we_first) we_n = 1'b0; else ce_n = 1'b0;
    repeat (3) @(negedge clk);
    addr = a;
    we_n = 1'b0; ce_n = 1'b0;
    repeat (4) @(negedge clk);
    addr = a ^ 20'h00333; din = d2;
    repeat (3) @(negedge clk);
    if (we_first) ce_n = 1'b1; else we_n = 1'b1;
    repeat (3) @(negedge clk);
    din = d3;
    repeat (2) @(negedge clk);
    we_n = 1'b1; ce_n = 1'b1;
    repeat (5) @(negedge clk);
  endtask

  task automatic key3(input logic [7:0] c);
    wr(20'h05555, 16'h00AA);
    wr(20'h02AAA, 16'h0055);
    wr(20'h05555, {8'h00, c});
  endtask

  task automatic erase_pre();
    key3(8'h80);
    wr(20'h05555, 16'h00AA);
    wr(20'h02AAA, 16'h0055);
  endtask

  task automatic done_pulse();
    @(negedge clk); op_done = 1'b1;
    @(negedge clk); op_done = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    #(CLK_P * 150000);
    checks++;
    errs++;
    $display("FAIL watchdog expired actual=running expected=finished");
    summary();
  end

  initial begin
    int base;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    repeat (2) @(negedge clk);

    // R1 reset state
    chk("R1 mode", read_mode, 0);
    chk("R1 busy", busy, 0);
    chk("R1 op_valid", op_valid, 0);
    chk("R1 id_word", id_word, 0);

    // R3 program
    base = op_cnt;
    key3(8'hA0);
    wr(20'hABCDE, 16'h1234);
    chk("R3 count", op_cnt - base, 1);
    chk("R3 type", m_type, 0);
    chk("R3 addr", m_addr, 20'hABCDE);
    chk("R3 data", m_data, 16'h1234);
    chk("R11 busy set", busy, 1);
    done_pulse();
    chk("R11 busy clear", busy, 0);

    // R2 strobe ordering, both leading strobes
    for (int w = 0; w < 2; w++) begin
      base = op_cnt;
      key3(8'hA0);
      wr_split(20'h3C0F1 + 20'(w), 16'h1111, 16'h2222 + 16'(w), 16'h3333, w[0]);
      chk("R2 count", op_cnt - base, 1);
      chk("R2 addr later fall", m_addr, 20'h3C0F1 + 20'(w));
      chk("R2 data earlier rise", m_data, 16'h2222 + 16'(w));
      done_pulse();
    end

    // R4 / R5 erase addresses
    for (int i = 0; i < 6; i++) begin
      logic [19:0] a;
      a = 20'(i * 20'h2B6E5 + 20'h00137);
      base = op_cnt;
      erase_pre();
      wr(a, 16'hCC30);
      chk("R4 type", m_type, 1);
      chk("R4 addr", m_addr, a & 20'hFFC00);
      chk("R4 count", op_cnt - base, 1);
      done_pulse();
      base = op_cnt;
      erase_pre();
      wr(a, 16'h0050);
      chk("R5 type", m_type, 2);
      chk("R5 addr", m_addr, a & 20'hF8000);
      chk("R5 count", op_cnt - base, 1);
      done_pulse();
    end

    // R6 chip erase at a wrong address raises nothing
    base = op_cnt;
    erase_pre();
    wr(20'h01234, 16'h0010);
    chk("R6 wrong addr", op_cnt - base, 0);
    chk("R6 busy", busy, 0);

    // sweep of the final erase byte (R4 R5 R6 R10)
    for (int v = 0; v < 256; v++) begin
      logic [7:0] b;
      b = 8'(v);
      base = op_cnt;
      erase_pre();
      wr(20'hF5555, {~b, b});
      if (b == 8'h30 || b == 8'h50 || b == 8'h10) begin
        chk("R10 sweep6 count", op_cnt - base, 1);
        if (b == 8'h30) chk("R4 sweep6", {m_type, m_addr}, {2'd1, 20'hF5400});
        if (b == 8'h50) chk("R5 sweep6", {m_type, m_addr}, {2'd2, 20'hF0000});
        if (b == 8'h10) chk("R6 sweep6", {m_type, m_addr}, {2'd3, 20'h00000});
        done_pulse();
      end else begin
        chk("R10 sweep6 no op", {op_cnt - base, busy}, 0);
      end
    end

    // sweep of the third unlock byte (R7 R8 R9 R10)
    for (int v = 0; v < 256; v++) begin
      logic [7:0] b;
      logic [1:0] em;
      b = 8'(v);
      base = op_cnt;
      wr(20'hA5555, 16'h77AA);
      wr(20'h52AAA, 16'h9955);
      wr(20'h35555, {b ^ 8'h5A, b});
      em = (b == 8'h90) ? 2'd1 : (b == 8'h98) ? 2'd2 : 2'd0;
      chk("R10 sweep3 mode", read_mode, em);
      chk("R10 sweep3 no op", op_cnt - base, 0);
      if (b == 8'hA0) begin
        wr(20'h00042, 16'hBEEF);
        chk("R3 sweep3 prog", {op_cnt - base, m_addr, m_data}, {32'd1, 20'h00042, 16'hBEEF});
        done_pulse();
      end else begin
        wr(20'h00000, 16'h00F0);
        chk("R9 sweep3 exit", read_mode, 0);
      end
    end

    // R7 identification reads
    key3(8'h90);
    chk("R7 mode", read_mode, 1);
    @(negedge clk); addr = 20'h00000; repeat (2) @(negedge clk);
    chk("R7 mfr", id_word, 16'h00BF);
    addr = 20'h00001; repeat (2) @(negedge clk);
    chk("R7 dev", id_word, 16'h2761);
    addr = 20'h00002; repeat (2) @(negedge clk);
    chk("R7 other", id_word, 0);
    addr = 20'h10000; repeat (2) @(negedge clk);
    chk("R7 high bits", id_word, 0);
    wr(20'h12345, 16'h00F0);
    chk("R9 single exit", read_mode, 0);
    addr = 20'h00000; repeat (2) @(negedge clk);
    chk("R7 array quiet", id_word, 0);

    // R8 query mode survives stray and aborted writes
    key3(8'h98);
    chk("R8 enter", read_mode, 2);
    wr(20'h00000, 16'h0012);
    chk("R8 stray", read_mode, 2);
    key3(8'h33);
    chk("R8 aborted", read_mode, 2);
    key3(8'hF0);
    chk("R9 three-write exit", read_mode, 0);

    // R10 corruption at each erase step, then a clean program
    for (int s = 0; s < 6; s++) begin
      logic [19:0] sa [6];
      logic [7:0]  sd [6];
      sa = '{20'h05555, 20'h02AAA, 20'h05555, 20'h05555, 20'h02AAA, 20'h01C00};
      sd = '{8'hAA, 8'h55, 8'h80, 8'hAA, 8'h55, 8'h30};
      base = op_cnt;
      for (int k = 0; k < 6; k++) begin
        if (k == s) wr(sa[k] ^ 20'h00001, {8'h00, sd[k] ^ 8'h01});
        else        wr(sa[k], {8'h00, sd[k]});
      end
      chk("R10 step abort", {op_cnt - base, busy}, 0);
      chk("R10 mode kept", read_mode, 0);
      key3(8'hA0);
      wr(20'h00777, 16'h5A5A);
      chk("R10 restart", op_cnt - base, 1);
      done_pulse();
    end

    // R11 writes ignored while busy, exit included
    key3(8'h90);
    base = op_cnt;
    key3(8'hA0);
    wr(20'h00100, 16'h0001);
    chk("R11 issued", op_cnt - base, 1);
    wr(20'h00000, 16'h00F0);
    chk("R11 exit ignored", read_mode, 1);
    key3(8'h98);
    chk("R11 entry ignored", read_mode, 1);
    key3(8'hA0);
    wr(20'h00200, 16'h0002);
    chk("R11 no second op", op_cnt - base, 1);
    done_pulse();
    wr(20'h00000, 16'h00F0);
    chk("R11 exit after done", read_mode, 0);

    // R12 done coinciding with a decoded write
    base = op_cnt;
    key3(8'hA0);
    wr(20'h00300, 16'h0003);
    wr_done(20'h05555, 16'h00AA);
    chk("R12 busy clear", busy, 0);
    wr(20'h02AAA, 16'h0055);
    wr(20'h05555, 16'h00A0);
    wr(20'h00400, 16'h0004);
    chk("R12 accepted", {op_cnt - base, m_addr}, {32'd2, 20'h00400});
    done_pulse();
    base = op_cnt;
    key3(8'hA0);
    wr(20'h00500, 16'h0005);
    wr(20'h05555, 16'h00AA);
    done_pulse();
    wr(20'h02AAA, 16'h0055);
    wr(20'h05555, 16'h00A0);
    wr(20'h00000, 16'h0077);
    chk("R12 control", op_cnt - base, 1);

    // R13 single-cycle requests throughout
    chk("R13 pulse width", dbl, 0);
    summary();
  end

endmodule